// File: doc/BRIEF.md
# Sequential Signed/Unsigned Shift-Add Multiplier

This block multiplies a multiplicand of `A_W` bits by a multiplier of `B_W` bits and returns the full product of `A_W + B_W` bits. It uses one adder and spends one clock on each multiplier bit. The `is_signed` input chooses between an unsigned product and a two's-complement product. That choice, and both operands, are captured when a start request is accepted. Inputs that arrive while the block is busy cannot disturb the operation in progress.

On each step the multiplicand is extended to the product width and shifted left by the current bit index. If the multiplier bit is 1, this shifted value is added into a double-width accumulator. Unsigned mode extends with zeros and visits every multiplier bit. Signed mode extends with the multiplicand's sign and visits only the low `B_W-1` bits. It then spends one fix-up cycle on the multiplier's top bit, which carries a negative weight. If that bit is 1, the fix-up subtracts the multiplicand shifted by `B_W-1`. The subtraction is done by adding the inverted value with a carry-in of one.

The controller has three states. `ST_IDLE` waits, and moves to `ST_ACCUM` on an accepted start. `ST_ACCUM` performs one bit step per clock. When it reaches the last step it goes to `ST_IDLE` in unsigned mode, or to `ST_FIXUP` in signed mode. `ST_FIXUP` performs the correction and returns to `ST_IDLE`. In signed mode with a one-bit multiplier, `ST_IDLE` goes straight to `ST_FIXUP`. In both modes `done` pulses for one cycle, exactly `B_W` clocks after the start edge. The product then stays unchanged until the next accepted start.

Top module: `seq_mul`

## Requirements
- R1: `product` is `A_W + B_W` bits wide. Both operand widths must be at least 1, and an elaboration-time check rejects a zero width.
- R2: On the clock edge that accepts `start` (high while `busy` is low), the accumulator is cleared, so `product` reads 0 in the following cycle.
- R3: With `is_signed` = 0 captured, `product` equals the unsigned product of `mcand` and `mplier`, including the operand values 0 and all ones.
- R4: With `is_signed` = 1 captured, `product` equals the two's-complement product of the two operands, modulo 2^(A_W+B_W). The negative weight of the multiplier's top bit is applied in the fix-up cycle only when that bit is 1. This holds for the most negative values, -1 and 0.
- R5: `busy` is high from the cycle after the start edge until `done` rises. `done` is high for exactly one cycle, `B_W` clock edges after the start edge, in both modes, and `busy` is low in that cycle.
- R6: While no start is accepted, `product` keeps its last value, whatever the operand and mode inputs do.
- R7: `start` asserted while `busy` is high is ignored. The running operation completes with its original operands, and its timing is unchanged.
- R8: A change of `is_signed` while `busy` is high has no effect on the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a multiplication; accepted only when idle |
| is_signed | input | 1 | 1 selects a two's-complement product, 0 an unsigned product |
| mcand | input | A_W | Multiplicand operand |
| mplier | input | B_W | Multiplier operand |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | A_W+B_W | Full-width product, held until the next start |

## Verification
Unsigned runs use zero, all ones and single-bit operands, which separate a missing carry ripple from a skipped top multiplier bit. Signed runs use the most negative values, -1, zero and the largest positive multiplicand. These cases separate a wrong sign extension, a skipped fix-up and a fix-up applied when the top bit is clear. Random operand pairs in both modes cover the remaining combinations. Start and mode toggled while busy, and operands changed while idle, show that captured state and the held product cannot be disturbed.

// File: rtl/seq_mul_pkg.sv
package seq_mul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ACCUM = 2'd1,
        ST_FIXUP = 2'd2
    } mul_state_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/seq_mul_ctrl.sv
module seq_mul_ctrl
    import seq_mul_pkg::*;
#(
    parameter int B_W = 6,
    parameter int IW  = idx_width(B_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          mode_in,
    output logic          load,
    output logic          accum,
    output logic          fix,
    output logic          mode_q,
    output logic [IW-1:0] idx,
    output logic          busy,
    output logic          done
);

    localparam logic [IW-1:0] U_LAST = IW'(B_W - 1);
    localparam logic [IW-1:0] S_LAST = IW'((B_W > 1) ? (B_W - 2) : 0);
    localparam bit            ONE_BIT = (B_W == 1);

    mul_state_e    state_q, state_d;
    logic          at_last;
    logic          done_q;
    logic [IW-1:0] idx_q;

    assign at_last = (idx_q == (mode_q ? S_LAST : U_LAST));
    assign load    = (state_q == ST_IDLE) && start;
    assign accum   = (state_q == ST_ACCUM);
    assign fix     = (state_q == ST_FIXUP);
    assign busy    = (state_q != ST_IDLE);
    assign idx     = idx_q;
    assign done    = done_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (mode_in && ONE_BIT) ? ST_FIXUP : ST_ACCUM;
                end
            end
            ST_ACCUM: begin
                if (at_last) begin
                    state_d = mode_q ? ST_FIXUP : ST_IDLE;
                end
            end
            ST_FIXUP: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // registered outputs: bit index, captured mode, completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            mode_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (accum && at_last && !mode_q) || fix;
            if (load) begin
                idx_q  <= '0;
                mode_q <= mode_in;
            end else if (accum) begin
                idx_q <= idx_q + IW'(1);
            end
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));                          // R5
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        accum |-> (idx_q <= (mode_q ? S_LAST : U_LAST)));          // R3
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mode_q));                                // R8

endmodule

// File: rtl/seq_mul_pp.sv
module seq_mul_pp
    import seq_mul_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 6,
    parameter int P_W = A_W + B_W,
    parameter int IW  = idx_width(B_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [A_W-1:0] mcand_in,
    input  logic [B_W-1:0] mplier_in,
    input  logic           mode,
    input  logic           accum,
    input  logic           fix,
    input  logic [IW-1:0]  idx,
    output logic           add_en,
    output logic [P_W-1:0] addend,
    output logic           cin
);

    localparam int FIX_SH = B_W - 1;

    logic [A_W-1:0] mcand_q;
    logic [B_W-1:0] mplier_q;
    logic [P_W-1:0] ext;
    logic           fill;

    // operand capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q  <= '0;
            mplier_q <= '0;
        end else if (load) begin
            mcand_q  <= mcand_in;
            mplier_q <= mplier_in;
        end
    end

    // extension fill: the sign in signed mode, zero otherwise
    assign fill = mode & mcand_q[A_W-1];

    assign ext[A_W-1:0] = mcand_q;
    for (genvar k = A_W; k < P_W; k++) begin : g_fill
        assign ext[k] = fill;
    end

    // partial product selection
    always_comb begin
        add_en = 1'b0;
        addend = '0;
        cin    = 1'b0;
        if (accum) begin
            add_en = mplier_q[idx];
            addend = ext << idx;
        end else if (fix) begin
            add_en = mplier_q[B_W-1];
            addend = ~(ext << FIX_SH);
            cin    = 1'b1;
        end
    end

    AST_OPS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(mcand_q) && $stable(mplier_q)));        // R7
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(accum && fix));                                          // R4

endmodule

// File: rtl/seq_mul_acc.sv
module seq_mul_acc #(
    parameter int P_W = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           add_en,
    input  logic [P_W-1:0] addend,
    input  logic           cin,
    output logic [P_W-1:0] acc
);

    logic [P_W-1:0] acc_q;
    logic [P_W-1:0] sum;

    // the carry ripples through the whole width; the final carry out is discarded
    assign sum = acc_q + addend + {{(P_W-1){1'b0}}, cin};
    assign acc = acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (load) begin
            acc_q <= '0;
        end else if (add_en) begin
            acc_q <= sum;
        end
    end

    AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (acc_q == '0));                                   // R2
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !add_en) |=> $stable(acc_q));                    // R6

endmodule

// File: rtl/seq_mul.sv
module seq_mul
    import seq_mul_pkg::*;
#(
    parameter int A_W = 8,
    parameter int B_W = 6,
    localparam int P_W = A_W + B_W,
    localparam int IW  = idx_width(B_W)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic           is_signed,
    input  logic [A_W-1:0] mcand,
    input  logic [B_W-1:0] mplier,
    output logic           busy,
    output logic           done,
    output logic [P_W-1:0] product
);

    initial begin
        AST_WIDTH_NONZERO: assert (A_W >= 1 && B_W >= 1)
            else $error("seq_mul: operand widths must be at least one bit"); // R1
    end

    logic          load;
    logic          accum;
    logic          fix;
    logic          mode_q;
    logic [IW-1:0] idx;
    logic          add_en;
    logic [P_W-1:0] addend;
    logic          cin;

    seq_mul_ctrl #(
        .B_W (B_W),
        .IW  (IW)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .mode_in (is_signed),
        .load    (load),
        .accum   (accum),
        .fix     (fix),
        .mode_q  (mode_q),
        .idx     (idx),
        .busy    (busy),
        .done    (done)
    );

    seq_mul_pp #(
        .A_W (A_W),
        .B_W (B_W),
        .P_W (P_W),
        .IW  (IW)
    ) u_pp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .mcand_in  (mcand),
        .mplier_in (mplier),
        .mode      (mode_q),
        .accum     (accum),
        .fix       (fix),
        .idx       (idx),
        .add_en    (add_en),
        .addend    (addend),
        .cin       (cin)
    );

    seq_mul_acc #(
        .P_W (P_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .add_en (add_en),
        .addend (addend),
        .cin    (cin),
        .acc    (product)
    );

    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));                                          // R5
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));                   // R6

endmodule

// File: tb/tb_seq_mul.sv
`timescale 1ns/100ps
module tb_seq_mul;

    localparam int A_W = 8;
    localparam int B_W = 6;
    localparam int P_W = A_W + B_W;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start = 1'b0;
    logic           is_signed = 1'b0;
    logic [A_W-1:0] mcand = '0;
    logic [B_W-1:0] mplier = '0;
    logic           busy;
    logic           done;
    logic [P_W-1:0] product;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    seq_mul #(.A_W(A_W), .B_W(B_W)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_signed (is_signed),
        .mcand     (mcand),
        .mplier    (mplier),
        .busy      (busy),
        .done      (done),
        .product   (product)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [P_W-1:0] model(input logic [A_W-1:0] a,
                                             input logic [B_W-1:0] b,
                                             input bit s);
        longint x;
        longint y;
        if (s) begin
            x = longint'($signed(a));
            y = longint'($signed(b));
        end else begin
            x = longint'(a);
            y = longint'(b);
        end
        return P_W'(x * y);
    endfunction

    // waits for done, returning the number of falling edges counted
    task automatic wait_done(output int k);
        k = 0;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        if (!done) chk("R5 watchdog", 0, 1);
    endtask

    task automatic run_op(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                          input bit s, input string req);
        logic [P_W-1:0] exp;
        int k;
        exp = model(a, b, s);
        @(negedge clk);
        mcand = a; mplier = b; is_signed = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R2 cleared", product, 0);
        chk("R5 busy", busy, 1);
        wait_done(k);
        chk(req, product, exp);
        chk("R5 latency", k, B_W);
        @(negedge clk);
        chk("R5 pulse", done, 0);
        chk("R5 idle", busy, 0);
        chk("R6 held", product, exp);
    endtask

    task automatic t_reset();
        chk("R5 reset busy", busy, 0);
        chk("R5 reset done", done, 0);
        chk("R2 reset product", product, 0);
    endtask

    task automatic t_unsigned_corners();
        run_op(8'h00, 6'h00, 1'b0, "R3 zero");
        run_op(8'hFF, 6'h3F, 1'b0, "R3 all ones");
        run_op(8'hFF, 6'h01, 1'b0, "R3 ones x1");
        run_op(8'h01, 6'h3F, 1'b0, "R3 1 x ones");
        run_op(8'h80, 6'h20, 1'b0, "R3 top bits");
        run_op(8'h00, 6'h3F, 1'b0, "R3 zero mcand");
        run_op(8'hA5, 6'h00, 1'b0, "R3 zero mplier");
    endtask

    task automatic t_signed_corners();
        run_op(8'h80, 6'h20, 1'b1, "R4 most neg both");
        run_op(8'hFF, 6'h3F, 1'b1, "R4 minus one both");
        run_op(8'h7F, 6'h20, 1'b1, "R4 max pos x most neg");
        run_op(8'h80, 6'h1F, 1'b1, "R4 most neg x max pos");
        run_op(8'h00, 6'h20, 1'b1, "R4 zero x most neg");
        run_op(8'h05, 6'h1F, 1'b1, "R4 no fixup");
        run_op(8'hFB, 6'h3D, 1'b1, "R4 neg x neg");
        run_op(8'h80, 6'h00, 1'b1, "R4 most neg x zero");
    endtask

    task automatic t_random();
        for (int i = 0; i < 40; i++) begin
            run_op(A_W'($urandom), B_W'($urandom), bit'(i % 2), "R3 R4 random");
        end
    endtask

    // R7, R8: start and mode toggled during busy are ignored
    task automatic t_busy_inputs();
        logic [P_W-1:0] exp;
        int k;
        exp = model(8'hF3, 6'h25, 1'b0);
        @(negedge clk);
        mcand = 8'hF3; mplier = 6'h25; is_signed = 1'b0; start = 1'b1;
        @(negedge clk);
        mcand = 8'h11; mplier = 6'h03; is_signed = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 100) begin
            @(negedge clk);
            k++;
        end
        chk("R7 R8 result", product, exp);
        chk("R7 latency", k, B_W);
        @(negedge clk);
        chk("R7 no restart", busy, 0);
    endtask

    task automatic t_hold();
        logic [P_W-1:0] exp;
        run_op(8'h9C, 6'h2B, 1'b1, "R4 pre-hold");
        exp = model(8'h9C, 6'h2B, 1'b1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            mcand = A_W'(i * 37); mplier = B_W'(i * 11); is_signed = bit'(i % 2);
        end
        chk("R6 hold", product, exp);
        chk("R6 idle", busy, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            chk("watchdog", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unsigned_corners();
        t_signed_corners();
        t_random();
        t_busy_inputs();
        t_hold();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule